// File: doc/BRIEF.md
# Store buffer with store fence

This block sits between a simple in-order core and a single-port memory and holds the core's stores until they can be written. A write counts as globally visible at the clock edge where the memory accepts it (`mem_valid` and `mem_ready` both high). The core offers four kinds of request on one valid/ready port: ordinary stores, weakly ordered stores, store fences and serialize requests. Ordinary stores, weakly ordered stores and fences enter an ordered queue. Weakly ordered stores leave the queue head into a small combining area. Writes to the same word merge there, and lines flush in any order.

A fence at the queue head waits only for the combining area to drain. When no weakly ordered store is pending, it retires at once. A serialize request is never stored. It is held off until every store has reached memory, and the core can issue nothing behind it until then. Writes reach memory through one output register, which keeps the address and data steady while the memory stalls.

Top module: `store_fence_buffer`

## Requirements
- R1: Ordinary stores are written to memory in the order the core issued them.
- R2: A weakly ordered store to a word that already holds an unflushed line merges into that line. Only the newest data for that word is written. No two valid lines ever hold the same address.
- R3: Every store accepted before a fence (`in_kind` 2) is written before any store accepted after that fence.
- R4: Two fences in a row both retire in order, and no store on either side is lost.
- R5: If no weakly ordered store is pending, a fence costs no memory cycles. The sequence ordinary, fence, ordinary is fully written no more than 3 cycles after the last one is accepted, with `mem_ready` held high.
- R6: The queue holds 8 entries, and one more store can wait in the output register. With memory stalled, exactly 9 stores are accepted before `in_ready` goes low. No accepted store is ever dropped.
- R7: A serialize request (`in_kind` 3) is accepted only while `buf_empty` is high, so it waits until every earlier store has been written.
- R8: After reset, `buf_empty` and `in_ready` are high and `mem_valid` is low. Whenever `buf_empty` is high, `mem_valid` is low.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values into the next cycle.

Request codes on `in_kind`: 0 ordinary store, 1 weakly ordered store, 2 fence, 3 serialize.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Core request valid |
| in_ready | output | 1 | Block can take the request on `in_kind` |
| in_kind | input | 2 | 0 ordinary, 1 weakly ordered, 2 fence, 3 serialize |
| in_addr | input | 32 | Store word address |
| in_data | input | 32 | Store data |
| mem_valid | output | 1 | Write offered to memory |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | 32 | Write address |
| mem_data | output | 32 | Write data |
| buf_empty | output | 1 | No store is held anywhere in the block |

## Verification
A corrupt queue pointer or counter shows at the memory port within a few cycles. It appears as a write out of order, a repeated write or a missing write, or as `in_ready` falling after a store count other than nine. A fence that retires too early puts a post-fence address in the write log ahead of a pre-fence one. A stale combining line shows up as an extra write, or as old data for a merged word, once the memory is released. A wrong empty indication lets a serialize request through while a write is still outstanding. The bench catches that at the handshake itself.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        OP_REG   = 2'd0,
        OP_NT    = 2'd1,
        OP_FENCE = 2'd2,
        OP_SER   = 2'd3
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } entry_t;
endpackage

// File: rtl/sbf_queue.sv
module sbf_queue
    import sbf_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  entry_t push_entry,
    input  logic   pop,
    output entry_t head,
    output logic   head_valid,
    output logic   full
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    typedef struct packed {
        entry_t [DEPTH-1:0] slot;
        logic   [PW-1:0]    rd;
        logic   [PW-1:0]    wr;
        logic   [CW-1:0]    cnt;
    } q_t;

    q_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.slot[q_q.wr] = push_entry;
            q_d.wr = (q_q.wr == PW'(DEPTH - 1)) ? '0 : q_q.wr + PW'(1);
        end
        if (pop) begin
            q_d.rd = (q_q.rd == PW'(DEPTH - 1)) ? '0 : q_q.rd + PW'(1);
        end
        q_d.cnt = q_q.cnt + CW'(push) - CW'(pop);
        head       = q_q.slot[q_q.rd];
        head_valid = (q_q.cnt != '0);
        full       = (q_q.cnt == CW'(DEPTH));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R6
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);
endmodule

// File: rtl/sbf_combine.sv
module sbf_combine
    import sbf_pkg::*;
#(
    parameter int unsigned LINES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [DATA_W-1:0] ins_data,
    output logic              ins_ok,
    input  logic              take,
    output logic              fl_valid,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_data,
    output logic              empty
);
    localparam int unsigned IW = (LINES > 1) ? $clog2(LINES) : 1;

    typedef struct packed {
        logic [LINES-1:0]             vld;
        logic [LINES-1:0][ADDR_W-1:0] addr;
        logic [LINES-1:0][DATA_W-1:0] data;
    } wc_t;

    wc_t s_q, s_d;
    logic [IW-1:0] fl_idx, hit_idx, free_idx;
    logic          hit, free, flushing;

    always_comb begin
        s_d      = s_q;
        fl_idx   = '0;
        hit_idx  = '0;
        free_idx = '0;
        hit      = 1'b0;
        free     = 1'b0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (s_q.vld[i]) fl_idx = IW'(i);
        end
        fl_valid = |s_q.vld;
        empty    = !fl_valid;
        fl_addr  = s_q.addr[fl_idx];
        fl_data  = s_q.data[fl_idx];
        flushing = fl_valid && take;
        if (flushing) s_d.vld[fl_idx] = 1'b0;
        for (int i = 0; i < LINES; i++) begin
            if (s_q.vld[i] && s_q.addr[i] == ins_addr &&
                !(flushing && fl_idx == IW'(i))) begin
                hit     = 1'b1;
                hit_idx = IW'(i);
            end
            if (!s_q.vld[i]) begin
                free     = 1'b1;
                free_idx = IW'(i);
            end
        end
        ins_ok = ins_valid && (hit || free);
        if (ins_ok) begin
            if (hit) begin
                s_d.data[hit_idx] = ins_data;
            end else begin
                s_d.vld[free_idx]  = 1'b1;
                s_d.addr[free_idx] = ins_addr;
                s_d.data[free_idx] = ins_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar i = 0; i < LINES; i++) begin : g_pair_i
        for (genvar j = i + 1; j < LINES; j++) begin : g_pair_j
            // R2
            unique_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(s_q.vld[i] && s_q.vld[j] && s_q.addr[i] == s_q.addr[j]));
        end
    end
endmodule

// File: rtl/store_fence_buffer.sv
module store_fence_buffer
    import sbf_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned LINES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [1:0]  in_kind,
    input  logic [31:0] in_addr,
    input  logic [31:0] in_data,
    output logic        mem_valid,
    input  logic        mem_ready,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_data,
    output logic        buf_empty
);
    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } out_t;

    out_t   o_q, o_d;
    entry_t q_head, q_in;
    logic   q_hv, q_full, q_push, q_pop;
    logic   wc_ins_valid, wc_ins_ok, wc_fl_valid, wc_empty;
    logic   [ADDR_W-1:0] wc_fl_addr;
    logic   [DATA_W-1:0] wc_fl_data;
    logic   is_ser, out_free, load_reg;

    sbf_queue #(.DEPTH(DEPTH)) i_queue (
        .clk(clk), .rst_n(rst_n), .push(q_push), .push_entry(q_in),
        .pop(q_pop), .head(q_head), .head_valid(q_hv), .full(q_full)
    );

    sbf_combine #(.LINES(LINES)) i_combine (
        .clk(clk), .rst_n(rst_n), .ins_valid(wc_ins_valid),
        .ins_addr(q_head.addr), .ins_data(q_head.data), .ins_ok(wc_ins_ok),
        .take(out_free), .fl_valid(wc_fl_valid), .fl_addr(wc_fl_addr),
        .fl_data(wc_fl_data), .empty(wc_empty)
    );

    always_comb begin
        is_ser    = (op_e'(in_kind) == OP_SER);
        out_free  = !o_q.valid || mem_ready;
        buf_empty = !q_hv && wc_empty && !o_q.valid;
        in_ready  = is_ser ? buf_empty : !q_full;
        q_push    = in_valid && in_ready && !is_ser;
        q_in      = '{op: op_e'(in_kind), addr: in_addr, data: in_data};

        wc_ins_valid = q_hv && (q_head.op == OP_NT);
        load_reg     = 1'b0;
        case (q_head.op)
            OP_REG:   begin
                load_reg = q_hv && out_free && !wc_fl_valid;
                q_pop    = load_reg;
            end
            OP_NT:    q_pop = wc_ins_ok;
            OP_FENCE: q_pop = q_hv && wc_empty;
            default:  q_pop = q_hv;
        endcase

        o_d = o_q;
        if (o_q.valid && mem_ready) o_d.valid = 1'b0;
        if (wc_fl_valid && out_free) begin
            o_d = '{valid: 1'b1, addr: wc_fl_addr, data: wc_fl_data};
        end else if (load_reg) begin
            o_d = '{valid: 1'b1, addr: q_head.addr, data: q_head.data};
        end

        mem_valid = o_q.valid;
        mem_addr  = o_q.addr;
        mem_data  = o_q.data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

    // R8
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_empty |-> !mem_valid);

    // R7
    ser_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_kind == 2'd3 && !buf_empty) |-> !in_ready);

    // R3
    fence_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_pop && q_head.op == OP_FENCE) |-> !wc_fl_valid);
endmodule

// File: tb/test_store_fence_buffer.sv
module test_store_fence_buffer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_kind = 2'd0;
    logic [31:0] in_addr = '0;
    logic [31:0] in_data = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        buf_empty;

    int n_chk = 0;
    int n_fail = 0;
    int wr_n = 0;
    logic [31:0] wr_addr [64];
    logic [31:0] wr_data [64];
    int n_acc = 0;
    int acc_at_block = -1;
    bit saw_block = 1'b0;
    bit acc_empty = 1'b0;
    int wr_at_acc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    store_fence_buffer i_store_fence_buffer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_kind(in_kind), .in_addr(in_addr), .in_data(in_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .buf_empty(buf_empty)
    );

    // write log, sampled just before each rising edge
    always @(negedge clk) begin
        #(CLK_PERIOD / 2 - 1);
        if (rst_n && mem_valid && mem_ready && wr_n < 64) begin
            wr_addr[wr_n] = mem_addr;
            wr_data[wr_n] = mem_data;
            wr_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] kind, input logic [31:0] a, input logic [31:0] d);
        in_valid = 1'b1; in_kind = kind; in_addr = a; in_data = d;
        #1;
        while (!in_ready) begin
            if (!saw_block) acc_at_block = n_acc;
            saw_block = 1'b1;
            @(negedge clk); #1;
        end
        acc_empty = buf_empty;
        wr_at_acc = wr_n;
        @(negedge clk);
        in_valid = 1'b0;
        n_acc++;
    endtask

    task automatic drain();
        mem_ready = 1'b1;
        while (!buf_empty) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic start();
        wr_n = 0; n_acc = 0; saw_block = 1'b0; acc_at_block = -1;
    endtask

    task automatic t_reset();
        chk(buf_empty === 1'b1, "R8 empty after reset", int'(buf_empty), 1);
        chk(in_ready === 1'b1, "R8 ready after reset", int'(in_ready), 1);
        chk(mem_valid === 1'b0, "R8 no write after reset", int'(mem_valid), 0);
    endtask

    task automatic t_program_order();
        start();
        fork
            for (int i = 0; i < 6; i++) push(2'd0, 32'h10 + i, 32'hA0 + i);
            for (int k = 0; k < 12; k++) begin
                @(negedge clk); mem_ready = (k % 3) != 0;
            end
        join
        drain();
        chk(wr_n == 6, "R1 write count", wr_n, 6);
        for (int i = 0; i < 6; i++)
            chk(wr_addr[i] == 32'h10 + i && wr_data[i] == 32'hA0 + i,
                "R1 program order", int'(wr_addr[i]), 32'h10 + i);
    endtask

    task automatic t_combine();
        start();
        mem_ready = 1'b0;
        push(2'd0, 32'h20, 32'h1);
        push(2'd1, 32'h30, 32'h5);
        push(2'd1, 32'h30, 32'h6);
        repeat (3) @(negedge clk);
        drain();
        chk(wr_n == 2, "R2 merged write count", wr_n, 2);
        chk(wr_addr[1] == 32'h30, "R2 merged address", int'(wr_addr[1]), 32'h30);
        chk(wr_data[1] == 32'h6, "R2 newest data", int'(wr_data[1]), 6);
    endtask

    task automatic t_fence();
        int pre_max, post_min;
        start();
        mem_ready = 1'b0;
        push(2'd1, 32'h100, 32'h1);
        push(2'd1, 32'h101, 32'h2);
        push(2'd0, 32'h102, 32'h3);
        push(2'd2, 32'h0, 32'h0);
        push(2'd0, 32'h200, 32'h4);
        push(2'd1, 32'h201, 32'h5);
        drain();
        pre_max = -1; post_min = 99;
        for (int i = 0; i < wr_n; i++) begin
            if (wr_addr[i] < 32'h200) pre_max = i;
            else if (post_min == 99) post_min = i;
        end
        chk(wr_n == 5, "R3 write count", wr_n, 5);
        chk(pre_max < post_min, "R3 pre-fence before post-fence", pre_max, post_min - 1);
    endtask

    task automatic t_two_fences();
        start();
        mem_ready = 1'b1;
        push(2'd1, 32'h40, 32'h7);
        push(2'd2, 32'h0, 32'h0);
        push(2'd2, 32'h0, 32'h0);
        push(2'd1, 32'h41, 32'h8);
        drain();
        chk(wr_n == 2, "R4 write count", wr_n, 2);
        chk(wr_addr[0] == 32'h40 && wr_addr[1] == 32'h41, "R4 order across fences",
            int'(wr_addr[0]), 32'h40);
    endtask

    task automatic t_fence_no_stall();
        int cyc;
        start();
        mem_ready = 1'b1;
        push(2'd0, 32'h50, 32'h1);
        push(2'd2, 32'h0, 32'h0);
        push(2'd0, 32'h51, 32'h2);
        cyc = 0;
        while (!buf_empty && cyc < 50) begin @(negedge clk); cyc++; end
        chk(cyc <= 3, "R5 fence without weak stores", cyc, 3);
        chk(wr_n == 2 && wr_addr[1] == 32'h51, "R5 both written", wr_n, 2);
    endtask

    task automatic t_full();
        start();
        mem_ready = 1'b0;
        fork
            for (int i = 0; i < 12; i++) push(2'd0, 32'h60 + i, 32'hB0 + i);
            begin
                repeat (16) @(negedge clk);
                chk(mem_valid === 1'b1 && mem_addr == 32'h60, "R9 held under stall",
                    int'(mem_addr), 32'h60);
                @(negedge clk);
                chk(mem_valid === 1'b1 && mem_addr == 32'h60 && mem_data == 32'hB0,
                    "R9 still held", int'(mem_data), 32'hB0);
                mem_ready = 1'b1;
            end
        join
        drain();
        chk(acc_at_block == 9, "R6 stores taken before full", acc_at_block, 9);
        chk(wr_n == 12, "R6 nothing dropped", wr_n, 12);
        for (int i = 0; i < 12; i++)
            chk(wr_addr[i] == 32'h60 + i, "R6 order after full", int'(wr_addr[i]), 32'h60 + i);
    endtask

    task automatic t_serialize();
        start();
        mem_ready = 1'b0;
        push(2'd0, 32'h70, 32'h1);
        fork
            push(2'd3, 32'h0, 32'h0);
            begin repeat (8) @(negedge clk); mem_ready = 1'b1; end
        join
        chk(saw_block, "R7 serialize held off", int'(saw_block), 1);
        chk(acc_empty === 1'b1, "R7 accepted only when empty", int'(acc_empty), 1);
        chk(wr_at_acc == 1, "R7 earlier store written first", wr_at_acc, 1);
        push(2'd0, 32'h71, 32'h2);
        drain();
        chk(wr_n == 2 && wr_addr[1] == 32'h71, "R7 later store after serialize", wr_n, 2);
        chk(buf_empty === 1'b1 && mem_valid === 1'b0, "R8 idle after drain", int'(mem_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            begin
                t_reset();
                t_program_order();
                t_combine();
                t_fence();
                t_two_fences();
                t_fence_no_stall();
                t_full();
                t_serialize();
            end
            begin
                repeat (WATCHDOG) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule